// File: doc/BRIEF.md
# Rate-Paced Video Output Stage

This stage lives entirely in the system clock domain, between one internal video channel and the output pins. Pixel words arrive with a qualifying valid strobe at whatever average rate the upstream crossing delivers. They are held in a first-word-fall-through FIFO and then released at a steady rate. When `fmt_half` is low, one word leaves on every system clock. When it is high, one word leaves on every second clock, paced by a 50%-duty enable. There is never a second clock.

A line is held back until the FIFO has built up a programmable reserve (`prefill`). This gives small frequency differences between the source and the system clock room to even out before they can break a line. Once a line has started, exactly `line_len` pixels are strobed out and the phase of the enable restarts, so every line begins on a known cycle. An empty FIFO in the middle of a line is flagged, and the line still keeps its length. Writes that find the FIFO full are discarded and counted.

Top module: `vid_pace_out`

## Requirements
- R1: After synchronous reset, `out_stb`, `out_sol` and `underrun` are 0, `ovf_count` is 0 and the FIFO is empty.
- R2: A line starts only when `line_len` is nonzero and the FIFO occupancy is at least `prefill`. The first strobe of the line comes on the second rising edge after the edge that brought the occupancy to the threshold, and `out_sol` is 1 together with that strobe only.
- R3: With `fmt_half`=0, strobes within a line come on consecutive cycles. With `fmt_half`=1 they are exactly two cycles apart, and the phase restarts at every line start.
- R4: Each line gives exactly `line_len` strobes. The stage then stays idle until the occupancy reaches `prefill` again.
- R5: Words come out on `out_data` in the order in which they were accepted.
- R6: If the FIFO is empty on an enabled cycle within a line, the strobe is still given, `out_data` repeats the previous word and `underrun` becomes 1.
- R7: `underrun` stays 1 until a cycle with `underrun_clr`=1 clears it. A new underrun in that same cycle wins over the clear.
- R8: A write that arrives while the FIFO holds DEPTH (default 64) words is dropped, and the stored words are left unchanged.
- R9: `ovf_count` increments by one for each dropped write and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write strobe for `in_data` |
| in_data | input | DW | Incoming pixel word |
| fmt_half | input | 1 | 0: one pixel per clock; 1: one pixel every second clock |
| prefill | input | AW+1 | FIFO occupancy required before a line may start |
| line_len | input | LW | Pixels per active line |
| underrun_clr | input | 1 | Write-one-to-clear for `underrun` |
| out_data | output | DW | Outgoing pixel word |
| out_stb | output | 1 | Pixel strobe, one cycle per pixel |
| out_sol | output | 1 | High with the first strobe of each line |
| underrun | output | 1 | Sticky mid-line empty flag |
| ovf_count | output | 8 | Saturating count of dropped writes |

## Verification
A wrong read pointer or occupancy count shows at the ports within a single line. The wrong word or word order appears on `out_data`, or a line starts at the wrong moment relative to the edge that reached the threshold. A wrong pixel counter or enable phase changes the number of strobes in a line, or the gap between them, from the very first line after reset. Dropped-write faults show up only once the FIFO is full: they show as a wrong `ovf_count` at once and as altered data when the stored words are finally read out.

// File: rtl/vpo_pkg.sv
package vpo_pkg;
    localparam int OVF_W = 8;

    typedef enum logic {
        LN_IDLE   = 1'b0,
        LN_ACTIVE = 1'b1
    } line_state_e;

    typedef struct packed {
        logic stb;
        logic sol;
    } pix_flags_t;

    function automatic logic [OVF_W-1:0] sat_inc(input logic [OVF_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/vpo_fifo.sv
module vpo_fifo
    import vpo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    input  logic             rd,
    output logic [DW-1:0]    rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic [OVF_W-1:0] ovf_count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp        <= '0;
            rp        <= '0;
            count     <= '0;
            ovf_count <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr && full) ovf_count <= sat_inc(ovf_count);
        end
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_drop_keeps_full_R8: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd) |=> (count == CW'(DEPTH)));
    assert_ovf_step_R9: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !(&ovf_count)) |=> (ovf_count == $past(ovf_count) + 1'b1));
    assert_ovf_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (&ovf_count) |=> (&ovf_count));
endmodule

// File: rtl/vpo_pacer.sv
module vpo_pacer (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic half,
    output logic en
);
    logic phase;

    assign en = active && (!half || !phase);

    always_ff @(posedge clk) begin
        if (rst)         phase <= 1'b0;
        else if (start)  phase <= 1'b0;
        else if (active) phase <= ~phase;
    end

    assert_half_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        (half && en) |=> (!en || !half));
endmodule

// File: rtl/vpo_line.sv
module vpo_line
    import vpo_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 7,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] prefill,
    input  logic [LW-1:0] line_len,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] fifo_count,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          start,
    output logic          active,
    output logic          fifo_rd,
    output logic [DW-1:0] out_data,
    output pix_flags_t    flags,
    output logic          underrun
);
    line_state_e   state;
    logic [LW-1:0] pix;
    logic          ready;

    assign ready   = (fifo_count >= prefill) && (line_len != '0);
    assign active  = (state == LN_ACTIVE);
    assign start   = (state == LN_IDLE) && ready;
    assign fifo_rd = active && en && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LN_IDLE;
            pix      <= '0;
            out_data <= '0;
            flags    <= '0;
            underrun <= 1'b0;
        end else begin
            flags <= '0;
            if (clr) underrun <= 1'b0;
            if (start) begin
                state <= LN_ACTIVE;
                pix   <= '0;
            end else if (active && en) begin
                flags.stb <= 1'b1;
                flags.sol <= (pix == '0);
                if (!fifo_empty) out_data <= fifo_data;
                else             underrun <= 1'b1;
                pix <= pix + 1'b1;
                if (pix == line_len - 1'b1) state <= LN_IDLE;
            end
        end
    end

    assert_underrun_repeat_R6: assert property (@(posedge clk) disable iff (rst)
        (active && en && fifo_empty) |=> (flags.stb && underrun && $stable(out_data)));
    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr) |=> underrun);
    assert_sol_with_stb_R2: assert property (@(posedge clk) disable iff (rst)
        flags.sol |-> flags.stb);
    assert_pix_in_line_R4: assert property (@(posedge clk) disable iff (rst)
        (active && $stable(line_len)) |-> (pix < line_len));
endmodule

// File: rtl/vid_pace_out.sv
module vid_pace_out
    import vpo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int LW    = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             fmt_half,
    input  logic [CW-1:0]    prefill,
    input  logic [LW-1:0]    line_len,
    input  logic             underrun_clr,
    output logic [DW-1:0]    out_data,
    output logic             out_stb,
    output logic             out_sol,
    output logic             underrun,
    output logic [OVF_W-1:0] ovf_count
);
    logic [DW-1:0] f_data;
    logic [CW-1:0] f_count;
    logic          f_empty, f_rd, en, start, active;
    pix_flags_t    flags;

    vpo_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr(in_valid), .wdata(in_data), .rd(f_rd),
        .rdata(f_data), .count(f_count), .empty(f_empty), .ovf_count(ovf_count)
    );

    vpo_pacer u_pacer (
        .clk(clk), .rst(rst), .start(start), .active(active),
        .half(fmt_half), .en(en)
    );

    vpo_line #(.DW(DW), .CW(CW), .LW(LW)) u_line (
        .clk(clk), .rst(rst), .prefill(prefill), .line_len(line_len),
        .clr(underrun_clr), .en(en), .fifo_count(f_count), .fifo_empty(f_empty),
        .fifo_data(f_data), .start(start), .active(active), .fifo_rd(f_rd),
        .out_data(out_data), .flags(flags), .underrun(underrun)
    );

    assign out_stb = flags.stb;
    assign out_sol = flags.sol;
endmodule

// File: tb/vid_pace_out_test.sv
module vid_pace_out_test;
    localparam int DW = 16;
    localparam int CW = 7;
    localparam int LW = 12;
    // half, line_len, prefill, writes, expected strobes, expected lines
    localparam int NV = 5;
    localparam int VEC [NV][6] = '{
        '{0, 16,  4, 16, 16, 1},
        '{1, 10,  2, 10, 10, 1},
        '{0,  8,  8,  8,  8, 1},
        '{1, 20, 32, 40, 20, 1},
        '{0,  5,  1, 10, 10, 2}
    };

    logic          clk = 1'b0, rst = 1'b1, in_valid = 1'b0, fmt_half = 1'b0, underrun_clr = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] prefill = 7'd4;
    logic [LW-1:0] line_len = 12'd8;
    logic [DW-1:0] out_data;
    logic          out_stb, out_sol, underrun;
    logic [7:0]    ovf_count;

    int checks = 0, errors = 0, wcnt = 0;
    int cyc = 0, last = 0, stb_cnt = 0, line_cnt = 0, rx = 0, d_err = 0, sp_err = 0, gap = 1;
    bit chk_data = 1'b1, done = 1'b0;

    vid_pace_out uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .fmt_half(fmt_half),
        .prefill(prefill), .line_len(line_len), .underrun_clr(underrun_clr),
        .out_data(out_data), .out_stb(out_stb), .out_sol(out_sol),
        .underrun(underrun), .ovf_count(ovf_count)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            cyc = cyc + 1;
            if (out_stb) begin
                stb_cnt = stb_cnt + 1;
                if (out_sol) line_cnt = line_cnt + 1;
                else if (cyc - last != gap) sp_err = sp_err + 1;
                last = cyc;
                if (chk_data && out_data != DW'(rx)) d_err = d_err + 1;
                rx = rx + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        cyc = 0; last = 0; stb_cnt = 0; line_cnt = 0; rx = 0; d_err = 0; sp_err = 0; wcnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DW'(wcnt);
            wcnt++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
            finish_up();
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(out_stb == 1'b0, "R1 out_stb after reset", out_stb, 0);
        chk(out_sol == 1'b0, "R1 out_sol after reset", out_sol, 0);
        chk(underrun == 1'b0, "R1 underrun after reset", underrun, 0);
        chk(ovf_count == 8'd0, "R1 ovf_count after reset", ovf_count, 0);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            fmt_half = VEC[v][0][0];
            line_len = LW'(VEC[v][1]);
            prefill  = CW'(VEC[v][2]);
            gap      = VEC[v][0] ? 2 : 1;
            chk_data = 1'b1;
            do_reset();
            push(VEC[v][3]);
            repeat (200) @(negedge clk);
            chk(stb_cnt == VEC[v][4], $sformatf("R4 vec%0d strobes", v), stb_cnt, VEC[v][4]);
            chk(line_cnt == VEC[v][5], $sformatf("R2 vec%0d lines", v), line_cnt, VEC[v][5]);
            chk(d_err == 0, $sformatf("R5 vec%0d data mismatches", v), d_err, 0);
            chk(sp_err == 0, $sformatf("R3 vec%0d strobe spacing errors", v), sp_err, 0);
            chk(underrun == 1'b0, $sformatf("R6 vec%0d no underrun", v), underrun, 0);
        end

        // R6 / R7 underrun: two words, line of eight
        fmt_half = 1'b0; line_len = 12'd8; prefill = 7'd2; gap = 1; chk_data = 1'b0;
        do_reset();
        push(2);
        repeat (30) @(negedge clk);
        chk(stb_cnt == 8, "R4 underrun line keeps length", stb_cnt, 8);
        chk(out_data == 16'd1, "R6 repeats last word", out_data, 1);
        chk(underrun == 1'b1, "R6 underrun set", underrun, 1);
        repeat (10) @(negedge clk);
        chk(underrun == 1'b1, "R7 underrun sticky", underrun, 1);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk(underrun == 1'b0, "R7 underrun cleared", underrun, 0);

        // R2 / R3 line start timing and phase restart, half rate
        fmt_half = 1'b1; line_len = 12'd3; prefill = 7'd4; gap = 2; chk_data = 1'b1;
        do_reset();
        for (int ln = 0; ln < 2; ln++) begin
            push(ln == 0 ? 4 : 3);
            chk(out_stb == 1'b0, "R2 no strobe one edge after threshold", out_stb, 0);
            @(negedge clk);
            chk(out_stb == 1'b0, "R2 no strobe at first edge", out_stb, 0);
            @(negedge clk);
            chk(out_stb == 1'b1 && out_sol == 1'b1, "R2 first strobe with sol at second edge",
                {out_stb, out_sol}, 3);
            repeat (20) @(negedge clk);
            chk(line_cnt == ln + 1, "R2 waits for threshold", line_cnt, ln + 1);
        end
        chk(stb_cnt == 6, "R4 two lines of three", stb_cnt, 6);
        chk(sp_err == 0, "R3 half rate spacing with phase restart", sp_err, 0);
        chk(d_err == 0, "R5 order across lines", d_err, 0);

        // R8 / R9 overflow and saturation
        fmt_half = 1'b0; line_len = 12'd8; prefill = 7'd100; gap = 1; chk_data = 1'b1;
        do_reset();
        push(70);
        repeat (5) @(negedge clk);
        chk(stb_cnt == 0, "R2 no line below threshold", stb_cnt, 0);
        chk(ovf_count == 8'd6, "R9 dropped writes counted", ovf_count, 6);
        push(300);
        chk(ovf_count == 8'd255, "R9 counter saturates", ovf_count, 255);
        prefill = 7'd64;
        repeat (30) @(negedge clk);
        chk(stb_cnt == 8, "R8 line after overflow", stb_cnt, 8);
        chk(d_err == 0, "R8 stored words unchanged by dropped writes", d_err, 0);

        done = 1'b1;
        finish_up();
    end
endmodule